// File: doc/BRIEF.md
# Fuse Array Read Controller

This block exposes a 512-byte one-time-programmable fuse store through a small 32-bit register bus with word-indexed accesses. Software powers the store up, enables automatic reading, latches a word address with a pulse on an address-capture bit, and then pulses a launch bit. A busy flag is raised at once and held while the fuse cells are sensed for a fixed number of cycles. When it drops, the fetched word is waiting in a separate data register. The fuse contents are modelled inside the block and preloaded from a parameter. The word size is a parameter of 1 or 4 bytes, and the address counts in words.

The sequencer is a two-state machine. `ST_IDLE` waits for an accepted launch; the LAUNCH transition moves to `ST_SENSE`, which loops on itself (SETTLE) while a cycle counter runs. The FINISH transition returns to `ST_IDLE` on the last sensing cycle and loads the data register in the same edge. The programming-side fields of the control register are storage only, and the encryption flag in the configuration register is stored but has no effect.

Top module: `efc_ctrl`

## Requirements
- R1: After reset the control register (word index 1, byte offset 0x04) reads 0x0800_0000 (only power-down, bit 27, set), the data register (word index 2) reads 0, and the configuration register (word index 4) reads 0.
- R2: The control register stores power-down (bit 27), launch (bit 25), read-enable (bit 24), program byte (bits 23:16), program-launch (bit 13), program-enable (bit 12), address-capture (bit 11) and word address (bits 10:0), and reads them back as written; bit 26 is the read-only busy flag, bit 14 always reads 0, and bits 31:28 and 15 read 0.
- R3: The configuration register stores only its bit 10; every other bit reads 0.
- R4: The word address is captured into the fetch address only in a write that takes the address-capture bit from 0 to 1; address writes without such a rise, or with the bit held at 1, leave the fetch address unchanged. The address used by a read is the one captured at launch.
- R5: A write that takes the launch bit from 0 to 1 while the same write has read-enable 1 and power-down 0, and no read is in progress, starts a read; busy reads 1 on the first register read after that write.
- R6: Busy stays 1 for exactly LATENCY clock cycles (default 8), then goes to 0 with the fetched word already in the data register.
- R7: A launch with power-down 1 or read-enable 0 is refused: busy stays 0 and the data register keeps its value.
- R8: With 4-byte words the data register returns fuse bytes 4a..4a+3 little-endian for word address a; with 1-byte words it returns byte a in bits 7:0 and zeros above. The default preload sets fuse byte k to (37*k + 11) mod 256.
- R9: A word address at or beyond 512/WORD_BYTES returns all zeros and still completes with busy cleared after LATENCY cycles.
- R10: A launch rise while busy is 1 is ignored (no restart, no extra busy cycles), and bus writes to the data register have no effect; the data register changes only when a read completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | REG_AW | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, valid while bus_sel=1 and bus_wr=0 |

## Verification
A launch write sampled at edge E0 shows busy on a read in the same cycle after E0, and busy first reads 0 in the cycle after edge E0+LATENCY, when the data register already holds the new word. The bench records the clock count at the launch write and compares the count at the first busy-free read against LATENCY, and reads the data register only after that point. Refused and ignored launches are checked by reading busy in the cycle right after the write and the data register after waiting longer than a full read would take. Register field storage is checked by a read immediately after each write, since reads are combinational.

// File: rtl/efc_pkg.sv
package efc_pkg;
    localparam int FUSE_BYTES  = 512;
    localparam int FUSE_ADDR_W = 11;

    // Register word indices on the bus
    localparam int REG_IDX_CTRL = 1;
    localparam int REG_IDX_DATA = 2;
    localparam int REG_IDX_CFG  = 4;

    // Control register bit positions
    localparam int BIT_PWR_DOWN  = 27;
    localparam int BIT_BUSY      = 26;
    localparam int BIT_LAUNCH    = 25;
    localparam int BIT_RD_EN     = 24;
    localparam int BIT_PGM_LO    = 16;
    localparam int BIT_PGM_LAUNCH = 13;
    localparam int BIT_PGM_EN    = 12;
    localparam int BIT_ADDR_CAP  = 11;
    localparam int BIT_CFG_CRYPT = 10;

    typedef enum logic {
        ST_IDLE,
        ST_SENSE
    } rd_state_t;

    function automatic logic [8*FUSE_BYTES-1:0] default_fuse_image();
        logic [8*FUSE_BYTES-1:0] img;
        img = '0;
        for (int k = 0; k < FUSE_BYTES; k++) begin
            img[8*k +: 8] = 8'((k * 37 + 11) % 256);
        end
        return img;
    endfunction
endpackage

// File: rtl/efc_fuse_rom.sv
module efc_fuse_rom
    import efc_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    parameter logic [8*FUSE_BYTES-1:0] FUSE_INIT = default_fuse_image()
) (
    input  logic [FUSE_ADDR_W-1:0] word_addr,
    output logic [31:0]            word_data
);
    localparam int WORD_COUNT = FUSE_BYTES / WORD_BYTES;
    localparam int IDX_W      = $clog2(WORD_COUNT);

    logic in_range;
    logic [IDX_W-1:0] idx;

    assign in_range = (word_addr < FUSE_ADDR_W'(WORD_COUNT));
    assign idx      = word_addr[IDX_W-1:0];

    generate
        if (WORD_BYTES == 4) begin : g_word4
            always_comb begin
                word_data = in_range ? FUSE_INIT[{idx, 5'b0} +: 32] : '0;
            end
        end else begin : g_word1
            always_comb begin
                word_data = in_range ? {24'h0, FUSE_INIT[{idx, 3'b0} +: 8]} : '0;
            end
        end
    endgenerate
endmodule

// File: rtl/efc_read_fsm.sv
module efc_read_fsm
    import efc_pkg::*;
#(
    parameter int LATENCY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic busy,
    output logic load
);
    localparam int CNT_W = $clog2(LATENCY + 1);

    rd_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             last_cycle;

    assign last_cycle = (cnt_q == CNT_W'(LATENCY - 1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Sensing cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n)                                 cnt_q <= '0;
        else if (state_q == ST_SENSE && !last_cycle) cnt_q <= cnt_q + 1'b1;
        else                                        cnt_q <= '0;
    end

    // Transitions: LAUNCH, SETTLE, FINISH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (launch)     state_d = ST_SENSE;
            ST_SENSE: if (last_cycle) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy = 1'b0;
        load = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_SENSE: begin
                busy = 1'b1;
                load = last_cycle;
            end
            default:  ;
        endcase
    end
endmodule

// File: rtl/efc_ctrl.sv
module efc_ctrl
    import efc_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    parameter int LATENCY    = 8,
    parameter int REG_AW     = 4,
    parameter logic [8*FUSE_BYTES-1:0] FUSE_INIT = default_fuse_image()
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    logic                   pwr_down_q, rd_en_q, launch_q;
    logic [7:0]             pgm_byte_q;
    logic                   pgm_launch_q, pgm_en_q, addr_cap_q;
    logic [FUSE_ADDR_W-1:0] addr_field_q, fetch_addr_q, sense_addr_q;
    logic                   crypt_q;
    logic [31:0]            data_q;

    logic ctrl_wr, cfg_wr, cap_rise, launch_rise, launch_ok;
    logic rd_busy, rd_load;
    logic [31:0] rom_word;
    logic unused_bits;

    assign ctrl_wr     = bus_sel && bus_wr && (bus_addr == REG_AW'(REG_IDX_CTRL));
    assign cfg_wr      = bus_sel && bus_wr && (bus_addr == REG_AW'(REG_IDX_CFG));
    assign cap_rise    = ctrl_wr && bus_wdata[BIT_ADDR_CAP] && !addr_cap_q;
    assign launch_rise = ctrl_wr && bus_wdata[BIT_LAUNCH] && !launch_q;
    assign launch_ok   = launch_rise && bus_wdata[BIT_RD_EN]
                         && !bus_wdata[BIT_PWR_DOWN] && !rd_busy;
    assign unused_bits = ^{bus_wdata[31:28], bus_wdata[BIT_BUSY], bus_wdata[15:14]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_down_q   <= 1'b1;
            rd_en_q      <= 1'b0;
            launch_q     <= 1'b0;
            pgm_byte_q   <= '0;
            pgm_launch_q <= 1'b0;
            pgm_en_q     <= 1'b0;
            addr_cap_q   <= 1'b0;
            addr_field_q <= '0;
        end else if (ctrl_wr) begin
            pwr_down_q   <= bus_wdata[BIT_PWR_DOWN];
            rd_en_q      <= bus_wdata[BIT_RD_EN];
            launch_q     <= bus_wdata[BIT_LAUNCH];
            pgm_byte_q   <= bus_wdata[BIT_PGM_LO +: 8];
            pgm_launch_q <= bus_wdata[BIT_PGM_LAUNCH];
            pgm_en_q     <= bus_wdata[BIT_PGM_EN];
            addr_cap_q   <= bus_wdata[BIT_ADDR_CAP];
            addr_field_q <= bus_wdata[FUSE_ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        crypt_q <= 1'b0;
        else if (cfg_wr)   crypt_q <= bus_wdata[BIT_CFG_CRYPT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        fetch_addr_q <= '0;
        else if (cap_rise) fetch_addr_q <= bus_wdata[FUSE_ADDR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         sense_addr_q <= '0;
        else if (launch_ok) sense_addr_q <= cap_rise ? bus_wdata[FUSE_ADDR_W-1:0] : fetch_addr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (rd_load) data_q <= rom_word;
    end

    efc_read_fsm #(.LATENCY(LATENCY)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch_ok),
        .busy   (rd_busy),
        .load   (rd_load)
    );

    efc_fuse_rom #(.WORD_BYTES(WORD_BYTES), .FUSE_INIT(FUSE_INIT)) u_rom (
        .word_addr (sense_addr_q),
        .word_data (rom_word)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                REG_AW'(REG_IDX_CTRL): bus_rdata = {4'b0, pwr_down_q, rd_busy, launch_q, rd_en_q,
                                                    pgm_byte_q, 1'b0, 1'b0, pgm_launch_q, pgm_en_q,
                                                    addr_cap_q, addr_field_q};
                REG_AW'(REG_IDX_DATA): bus_rdata = data_q;
                REG_AW'(REG_IDX_CFG):  bus_rdata = {21'b0, crypt_q, 10'b0};
                default:               bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/efc_ctrl_chk.sv
module efc_ctrl_chk
    import efc_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    parameter int LATENCY    = 8,
    parameter int REG_AW     = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ctrl_access,
    input logic                   en_bit,
    input logic                   pd_bit,
    input logic                   busy,
    input logic [31:0]            data_q,
    input logic [FUSE_ADDR_W-1:0] sense_addr
);
    localparam int WORD_COUNT = FUSE_BYTES / WORD_BYTES;

    logic [31:0] run_len;

    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    AST_LAUNCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ctrl_access && en_bit && !pd_bit)); // R5

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == 32'(LATENCY))); // R6

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> $stable(data_q)); // R10

    AST_OUT_OF_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && (sense_addr >= FUSE_ADDR_W'(WORD_COUNT))) |-> (data_q == 32'h0)); // R9
endmodule

bind efc_ctrl efc_ctrl_chk #(
    .WORD_BYTES (WORD_BYTES),
    .LATENCY    (LATENCY),
    .REG_AW     (REG_AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_access (ctrl_wr),
    .en_bit      (bus_wdata[efc_pkg::BIT_RD_EN]),
    .pd_bit      (bus_wdata[efc_pkg::BIT_PWR_DOWN]),
    .busy        (rd_busy),
    .data_q      (data_q),
    .sense_addr  (sense_addr_q)
);

// File: tb/efc_ctrl_test.sv
module efc_ctrl_test;
    localparam int N    = 8;
    localparam logic [3:0] A_CTRL = 4'd1;
    localparam logic [3:0] A_DATA = 4'd2;
    localparam logic [3:0] A_CFG  = 4'd4;
    localparam logic [31:0] RUN   = 32'h0100_0000; // read-enable=1, power-down=0
    localparam logic [31:0] CAP   = 32'h0000_0800;
    localparam logic [31:0] GO    = 32'h0200_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0;
    logic bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata4, rdata1;
    logic [31:0] r4, r1;
    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    efc_ctrl #(.WORD_BYTES(4), .LATENCY(N)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata4));

    efc_ctrl #(.WORD_BYTES(1), .LATENCY(N)) uut_b1 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata1));

    function automatic logic [7:0] fbyte(input int k);
        return 8'((k * 37 + 11) % 256);
    endfunction

    function automatic logic [31:0] exp4(input int a);
        if (a >= 128) return 32'h0;
        return {fbyte(4*a+3), fbyte(4*a+2), fbyte(4*a+1), fbyte(4*a)};
    endfunction

    function automatic logic [31:0] exp1(input int a);
        if (a >= 512) return 32'h0;
        return {24'h0, fbyte(a)};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        r4 = rdata4; r1 = rdata1;
        bus_sel = 1'b0;
    endtask

    // Launch with the address already captured; check timing and data.
    task automatic launch_and_wait(input int a, input bit retrigger);
        int e0;
        int span;
        wr(A_CTRL, RUN | GO);
        e0 = cyc;
        rd(A_CTRL);
        check("R5 busy right after launch", {31'h0, r4[26]}, 32'h1);
        if (retrigger) begin
            wr(A_CTRL, RUN);
            wr(A_CTRL, RUN | GO);
        end
        for (int i = 0; i < 4 * N; i++) begin
            rd(A_CTRL);
            if (!r4[26]) break;
            @(negedge clk);
        end
        span = cyc - e0;
        check(retrigger ? "R10 busy span with retrigger" : "R6 busy span", 32'(span), 32'(N));
        rd(A_DATA);
        check(a >= 128 ? "R9 word4 out of range" : "R8 word4 data", r4, exp4(a));
        check(a >= 512 ? "R9 word1 out of range" : "R8 word1 data", r1, exp1(a));
        if (retrigger) begin
            @(negedge clk);
            rd(A_CTRL);
            check("R10 no restart after retrigger", {31'h0, r4[26]}, 32'h0);
        end
        wr(A_CTRL, RUN);
    endtask

    task automatic fetch(input int a);
        wr(A_CTRL, RUN | 32'(a));
        wr(A_CTRL, RUN | CAP | 32'(a));
        wr(A_CTRL, RUN | 32'(a));
        launch_and_wait(a, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] held4, held1;
        int a;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL); check("R1 ctrl reset", r4, 32'h0800_0000); check("R1 ctrl reset b1", r1, 32'h0800_0000);
        rd(A_DATA); check("R1 data reset", r4, 32'h0);
        rd(A_CFG);  check("R1 cfg reset", r4, 32'h0);

        // R2 field storage and read-only bits
        wr(A_CTRL, 32'hFFAB_FFFF);
        rd(A_CTRL); check("R2 ctrl readback", r4, 32'h0BAB_3FFF);
        wr(A_CTRL, 32'h0800_0000);
        rd(A_CTRL); check("R2 ctrl readback idle", r4, 32'h0800_0000);

        // R3 configuration register
        wr(A_CFG, 32'hFFFF_FFFF);
        rd(A_CFG); check("R3 cfg only bit 10", r4, 32'h0000_0400);
        wr(A_CFG, 32'h0);
        rd(A_CFG); check("R3 cfg cleared", r4, 32'h0);

        // Directed boundaries: R8, R9
        fetch(0);
        fetch(127);
        fetch(128);
        fetch(511);
        fetch(512);
        fetch(2047);

        // R4: address write without capture rise keeps old fetch address
        fetch(5);
        wr(A_CTRL, RUN | 32'd9);
        launch_and_wait(5, 1'b0);
        // R4: capture bit held at 1 does not recapture
        wr(A_CTRL, RUN | CAP | 32'd17);
        wr(A_CTRL, RUN | CAP | 32'd40);
        wr(A_CTRL, RUN);
        launch_and_wait(17, 1'b0);

        // R10: retrigger while busy ignored
        wr(A_CTRL, RUN | CAP | 32'd33);
        wr(A_CTRL, RUN);
        launch_and_wait(33, 1'b1);

        // R7: power-down blocks launch
        rd(A_DATA); held4 = r4; held1 = r1;
        wr(A_CTRL, RUN | CAP | 32'd60);
        wr(A_CTRL, RUN);
        wr(A_CTRL, 32'h0800_0000 | RUN | GO);
        rd(A_CTRL); check("R7 power-down blocks busy", {31'h0, r4[26]}, 32'h0);
        repeat (N + 2) @(negedge clk);
        rd(A_DATA); check("R7 power-down data held", r4, held4); check("R7 power-down data held b1", r1, held1);
        wr(A_CTRL, RUN);
        // R7: read-enable low blocks launch
        wr(A_CTRL, GO);
        rd(A_CTRL); check("R7 disabled blocks busy", {31'h0, r4[26]}, 32'h0);
        repeat (N + 2) @(negedge clk);
        rd(A_DATA); check("R7 disabled data held", r4, held4);
        wr(A_CTRL, RUN);

        // R10: data register not writable
        wr(A_DATA, 32'hDEAD_BEEF);
        rd(A_DATA); check("R10 data write ignored", r4, held4); check("R10 data write ignored b1", r1, held1);

        // Random addresses, biased toward the low range
        for (int i = 0; i < 24; i++) begin
            if ($urandom % 2 == 0) a = int'($urandom % 140);
            else                   a = int'($urandom % 2048);
            fetch(a);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule